// File: doc/BRIEF.md
# Batch Dispatch Controller

This controller sits between one shared candidate generator and a row of worker cores. Each core has a fixed number of in-flight slots. After a work-block start, the controller turns the generator on and steers one candidate per cycle into core 0, then core 1, and so on, until every slot of every core has been loaded. It then switches the generator off and waits for the cores to drain. When all cores are idle again, it either begins a new batch or stops.

The controller stops for one of two reasons. The first is a match: any core reports that one of its slots hit, and the controller stops without waiting for the other cores. The second is exhaustion: the generator reports that it has no candidates left. In both cases the result is presented on a valid/ready output. A match is reported as a numeric offset from the first candidate of the block. The candidate value itself is never reported.

The result port follows valid/ready rules. `res_valid` rises with a verdict and stays high, with `res_found` and `res_offset` unchanged, until the cycle `res_ready` is sampled high. The block then returns to idle. The result cannot be lost, and while it waits no new block is started. All other pins are plain level or strobe signals.

Top module: `batch_dispatch_ctrl`

## Requirements
- R1: Each batch loads every core with exactly SLOTS strobes on `core_load`, one per cycle, in ascending core order. `gen_en` is high for NUM_CORES*SLOTS consecutive cycles per batch.
- R2: `gen_en` is high only in fill cycles. At most one `core_load` bit is high in any cycle, and never while `gen_en` is low.
- R3: During every load, `core_slot_valid` equals the inverse of `gen_done`. Slots loaded after the generator ran out are therefore marked invalid (0).
- R4: After a fill, the first wait cycle ignores `core_busy`. Later, when every `core_busy` bit is low, no match is pending and `gen_done` is low, a new fill begins.
- R5: When all cores are idle, no match is pending and `gen_done` is high, the result is `res_found`=0 with `res_offset`=0.
- R6: A match gives `res_found`=1 with `res_offset` = base + core*SLOTS + slot. Here base is `gen_count` in the batch's first fill cycle. A match seen in the wait phase ends it at once, even while other cores are busy, and it takes priority over exhaustion.
- R7: If several cores match in one cycle, the lowest core index wins. Once a match is captured, later matches do not change it.
- R8: `res_valid` stays high with a stable result until `res_ready` is high. The following cycle the block is idle, with `res_valid` and `gen_en` low.
- R9: `start` is acted on only in idle. A start pulse during fill, wait or a pending result changes nothing.
- R10: During and right after reset, `gen_en`, `core_load` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Work-block start pulse |
| gen_en | output | 1 | Generator advance enable |
| gen_done | input | 1 | Generator has no more candidates |
| gen_count | input | OFF_W | Index of the candidate currently offered by the generator |
| core_load | output | NUM_CORES | One-hot load strobe per core |
| core_slot_valid | output | 1 | Loaded slot holds a real candidate |
| core_busy | input | NUM_CORES | Core still processing its batch |
| core_match | input | NUM_CORES | Core found a hit (pulse) |
| core_match_slot | input | NUM_CORES*SLOT_W | Slot index of the hit, per core |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted |
| res_found | output | 1 | 1 = match, 0 = exhausted |
| res_offset | output | OFF_W | Offset of the matching candidate |

## Verification
Four properties are checked on every cycle: the length of each enable run, the one-hot load strobes, the stable result under back-pressure, and the rule that exhaustion is only declared with `gen_done` high. Only the bench scenarios can show the rest. This covers the offset arithmetic across cores and batches, refill after an idle drain, early termination while cores are still busy, lowest-index arbitration of simultaneous hits, the invalid marking of a partial batch, and start pulses that must be ignored.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_FOUND,
    ST_EXHAUST
  } disp_state_t;
endpackage

// File: rtl/dispatch_fill_seq.sv
module dispatch_fill_seq #(
  parameter int NUM_CORES = 4,
  parameter int SLOTS     = 83
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  output logic                 first,
  output logic                 last,
  output logic [NUM_CORES-1:0] load
);
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [CORE_W-1:0] core_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic              core_end;

  assign core_end = (slot_idx == SLOT_W'(SLOTS - 1));
  assign last     = run && core_end && (core_idx == CORE_W'(NUM_CORES - 1));
  assign first    = run && (slot_idx == '0) && (core_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      core_idx <= '0;
      slot_idx <= '0;
    end else if (core_end) begin
      slot_idx <= '0;
      core_idx <= last ? '0 : core_idx + 1'b1;
    end else begin
      slot_idx <= slot_idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_load
    assign load[g] = run && (core_idx == CORE_W'(g));
  end
endmodule

// File: rtl/dispatch_match_capture.sv
module dispatch_match_capture #(
  parameter int NUM_CORES = 4,
  parameter int SLOTS     = 83,
  parameter int OFF_W     = 32,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        enable,
  input  logic [NUM_CORES-1:0]        match,
  input  logic [NUM_CORES*SLOT_W-1:0] match_slot,
  input  logic [OFF_W-1:0]            base,
  output logic                        hit_now,
  output logic                        found,
  output logic [OFF_W-1:0]            offset
);
  logic [OFF_W-1:0]  sel_core;
  logic [SLOT_W-1:0] sel_slot;
  logic [OFF_W-1:0]  offset_now;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    sel_core = '0;
    sel_slot = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_core = OFF_W'(i);
        sel_slot = match_slot[i*SLOT_W +: SLOT_W];
      end
    end
  end

  assign hit_now    = enable && (|match);
  assign offset_now = base + sel_core * OFF_W'(SLOTS) + OFF_W'(sel_slot);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      found  <= 1'b0;
      offset <= '0;
    end else if (hit_now && !found) begin
      found  <= 1'b1;
      offset <= offset_now;
    end
  end
endmodule

// File: rtl/batch_dispatch_ctrl.sv
module batch_dispatch_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int SLOTS     = 83,
  parameter int OFF_W     = 32,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        gen_en,
  input  logic                        gen_done,
  input  logic [OFF_W-1:0]            gen_count,
  output logic [NUM_CORES-1:0]        core_load,
  output logic                        core_slot_valid,
  input  logic [NUM_CORES-1:0]        core_busy,
  input  logic [NUM_CORES-1:0]        core_match,
  input  logic [NUM_CORES*SLOT_W-1:0] core_match_slot,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic                        res_found,
  output logic [OFF_W-1:0]            res_offset
);
  import dispatch_pkg::*;

  disp_state_t      state_q, state_d;
  logic             fill_run, fill_first, fill_last;
  logic             arm_q;
  logic [OFF_W-1:0] base_q;
  logic             cap_clear, cap_en, cap_hit, cap_found;
  logic [OFF_W-1:0] cap_off;

  assign fill_run  = (state_q == ST_FILL);
  assign cap_clear = (state_q == ST_IDLE) && start;
  assign cap_en    = fill_run || (state_q == ST_WAIT);

  dispatch_fill_seq #(.NUM_CORES(NUM_CORES), .SLOTS(SLOTS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (fill_run),
    .first (fill_first),
    .last  (fill_last),
    .load  (core_load)
  );

  dispatch_match_capture #(.NUM_CORES(NUM_CORES), .SLOTS(SLOTS), .OFF_W(OFF_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cap_clear),
    .enable     (cap_en),
    .match      (core_match),
    .match_slot (core_match_slot),
    .base       (base_q),
    .hit_now    (cap_hit),
    .found      (cap_found),
    .offset     (cap_off)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_FILL;
      ST_FILL:  if (fill_last) state_d = ST_WAIT;
      ST_WAIT: begin
        if (cap_found || cap_hit)            state_d = ST_FOUND;
        else if (arm_q && !(|core_busy))     state_d = gen_done ? ST_EXHAUST : ST_FILL;
      end
      ST_FOUND, ST_EXHAUST: if (res_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      arm_q   <= 1'b0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      arm_q   <= (state_q == ST_WAIT);
      if (fill_first) base_q <= gen_count;
    end
  end

  assign gen_en          = fill_run;
  assign core_slot_valid = fill_run && !gen_done;
  assign res_valid       = (state_q == ST_FOUND) || (state_q == ST_EXHAUST);
  assign res_found       = (state_q == ST_FOUND);
  assign res_offset      = (state_q == ST_FOUND) ? cap_off : '0;
endmodule

// File: rtl/batch_dispatch_chk.sv
module batch_dispatch_chk #(
  parameter int NUM_CORES = 4,
  parameter int SLOTS     = 83,
  parameter int OFF_W     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gen_en,
  input logic                 gen_done,
  input logic [NUM_CORES-1:0] core_load,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic                 res_found,
  input logic [OFF_W-1:0]     res_offset
);
  localparam int BATCH = NUM_CORES * SLOTS;

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= 0;
    else if (gen_en) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  AST_FILL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_en) |-> (run_len == BATCH)); // R1

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_load)); // R2

  AST_LOAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (core_load != '0) |-> gen_en); // R2

  AST_EXHAUST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_found) |-> gen_done); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_found) && $stable(res_offset))); // R8

  AST_NO_FILL_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !gen_en); // R8
endmodule

bind batch_dispatch_ctrl batch_dispatch_chk #(
  .NUM_CORES(NUM_CORES), .SLOTS(SLOTS), .OFF_W(OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gen_en     (gen_en),
  .gen_done   (gen_done),
  .core_load  (core_load),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_found  (res_found),
  .res_offset (res_offset)
);

// File: tb/batch_dispatch_ctrl_test.sv
module batch_dispatch_ctrl_test;
  localparam int NC = 3;
  localparam int SL = 6;
  localparam int SW = $clog2(SL);
  localparam int OW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              res_ready = 1'b0;
  logic              gen_restart = 1'b0;
  logic              gen_en, gen_done, core_slot_valid;
  logic              res_valid, res_found;
  logic [OW-1:0]     res_offset;
  logic [NC-1:0]     core_load, core_busy, core_match;
  logic [NC*SW-1:0]  core_match_slot;

  int n_chk = 0;
  int n_bad = 0;
  int total_q = 0;
  int tgt0 = -1;
  int tgt1 = -1;
  int gcnt;
  int lat [NC];
  int ld_total, ld_valid, r2_bad;

  batch_dispatch_ctrl #(.NUM_CORES(NC), .SLOTS(SL), .OFF_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .gen_en(gen_en), .gen_done(gen_done),
    .gen_count(OW'(gcnt)), .core_load(core_load), .core_slot_valid(core_slot_valid),
    .core_busy(core_busy), .core_match(core_match), .core_match_slot(core_match_slot),
    .res_valid(res_valid), .res_ready(res_ready), .res_found(res_found),
    .res_offset(res_offset)
  );

  // generator model
  assign gen_done = (gcnt >= total_q);
  always_ff @(posedge clk) begin
    if (!rst_n || gen_restart) gcnt <= 0;
    else if (gen_en && gcnt < total_q) gcnt <= gcnt + 1;
  end

  // core models
  int          lc   [NC];
  int          tmr  [NC];
  logic        hit  [NC];
  logic [SW-1:0] hslot [NC];
  always_ff @(posedge clk) begin
    for (int i = 0; i < NC; i++) begin
      if (!rst_n || gen_restart) begin
        lc[i] <= 0; tmr[i] <= 0; hit[i] <= 1'b0; hslot[i] <= '0;
        core_busy[i] <= 1'b0; core_match[i] <= 1'b0;
      end else begin
        core_match[i] <= 1'b0;
        if (core_load[i]) begin
          if (core_slot_valid && (gcnt == tgt0 || gcnt == tgt1)) begin
            hit[i] <= 1'b1; hslot[i] <= SW'(lc[i]);
          end
          if (lc[i] == SL - 1) begin
            lc[i] <= 0; core_busy[i] <= 1'b1; tmr[i] <= lat[i];
          end else lc[i] <= lc[i] + 1;
        end else if (core_busy[i]) begin
          if (tmr[i] == 0) begin
            core_busy[i] <= 1'b0; core_match[i] <= hit[i]; hit[i] <= 1'b0;
          end else tmr[i] <= tmr[i] - 1;
        end
      end
    end
  end
  for (genvar g = 0; g < NC; g++) begin : g_slot
    assign core_match_slot[g*SW +: SW] = hslot[g];
  end

  // load counters
  always_ff @(posedge clk) begin
    if (!rst_n || gen_restart) begin
      ld_total <= 0; ld_valid <= 0;
    end else if (core_load != '0) begin
      ld_total <= ld_total + 1;
      if (core_slot_valid) ld_valid <= ld_valid + 1;
    end
  end

  // R2 monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (core_load != '0 && !gen_en) r2_bad++;
      if ($countones(core_load) > 1) r2_bad++;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_block(input int total, input int t0, input int t1,
                           input int poke_a, input int poke_b, input int hold,
                           input int e_found, input int e_off, input int e_valid,
                           input int e_total, input string lbl);
    int cyc;
    logic [OW-1:0] off_seen;
    @(negedge clk);
    total_q = total; tgt0 = t0; tgt1 = t1;
    start = 1'b1; gen_restart = 1'b1;
    @(negedge clk);
    start = 1'b0; gen_restart = 1'b0;
    cyc = 1;
    while (!res_valid && cyc < 5000) begin
      if (cyc == poke_a || cyc == poke_b) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk({lbl, " R8 result appears"}, res_valid, 1);
    chk({lbl, " R5/R6 found flag"}, res_found, e_found);
    chk({lbl, " R6 offset"}, res_offset, e_off);
    chk({lbl, " R3 valid loads"}, ld_valid, e_valid);
    chk({lbl, " R1/R4 total loads"}, ld_total, e_total);
    off_seen = res_offset;
    for (int h = 0; h < hold; h++) begin
      if (h == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({lbl, " R8/R9 held valid"}, res_valid, 1);
      chk({lbl, " R8 held offset"}, res_offset, off_seen);
      chk({lbl, " R8 no fill while held"}, gen_en, 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk({lbl, " R8 idle after accept"}, res_valid, 0);
    @(negedge clk);
    chk({lbl, " R9 stays idle"}, gen_en, 0);
  endtask

  // {total, target, found, offset, valid loads, total loads}
  localparam int VEC [8][6] = '{
    '{10, -1, 0,  0, 10, 18},
    '{18, -1, 0,  0, 18, 18},
    '{40, 25, 1, 25, 36, 36},
    '{40, 39, 1, 39, 40, 54},
    '{60,  0, 1,  0, 18, 18},
    '{36, 17, 1, 17, 18, 18},
    '{ 5,  4, 1,  4,  5, 18},
    '{ 0, -1, 0,  0,  0, 18}
  };

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < NC; i++) lat[i] = 10 + 3 * i;
    r2_bad = 0;
    repeat (3) @(negedge clk);
    chk("R10 gen_en in reset", gen_en, 0);
    chk("R10 core_load in reset", core_load, 0);
    chk("R10 res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 res_valid after reset", res_valid, 0);
    chk("R10 gen_en after reset", gen_en, 0);

    for (int v = 0; v < 8; v++) begin
      run_block(VEC[v][0], VEC[v][1], -1, 0, 0, 0,
                VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], $sformatf("vec%0d", v));
    end

    // R9: start pulses in fill and in wait are ignored
    run_block(40, 25, -1, 3, 25, 0, 1, 25, 36, 36, "R9 ignored start");
    // R8: back-pressure on the result, with a start pulse while held
    run_block(18, -1, -1, 0, 0, 6, 0, 0, 18, 18, "R8 backpressure");
    // R7: core 0 and core 2 report in the same cycle
    lat[0] = 18; lat[1] = 10; lat[2] = 6;
    run_block(18, 14, 3, 0, 0, 0, 1, 3, 18, 18, "R7 priority");
    for (int i = 0; i < NC; i++) lat[i] = 10 + 3 * i;

    chk("R2 load strobe rules", r2_bad, 0);
    summary();
  end
endmodule